// File: doc/BRIEF.md
# DMA Transfer Byte Counter with Periodic Pulse

This block tracks the number of bytes a simple DMA engine has moved or searched in the current block. Every transfer-done strobe advances a 16-bit count. The count is compared with a block length register. When the count reaches the length, one of two things happens. If auto-restart is off, the block stops and an end-of-block flag stays set. If auto-restart is on, the count returns to zero, the flag pulses for one clock and counting carries on. A load command clears the count and starts a new block.

The length register can be rewritten at any time between transfers. The comparison always uses the register's present contents; nothing is captured when a block starts. A separate 8-bit offset register is compared with the low byte of the count. Whenever a transfer moves the count onto a value whose low byte equals the offset, a one-clock pulse is produced. This happens once every 256 transfers after the offset. The pulse is only produced while bus request and bus acknowledge are both high, so it reaches external logic while the DMA owns the bus.

Control is a three-state machine. STOPPED_INIT is the state after reset, before any load. COUNTING is the active state. BLOCK_DONE is the stopped state after a block ends with auto-restart off. The transitions are:
- load: any state to COUNTING.
- finish: COUNTING to BLOCK_DONE, on a length match with auto-restart off.
- restart: COUNTING to COUNTING, on a length match with auto-restart on.
- advance: COUNTING to COUNTING, on any other strobe.

Top module: `dma_blk_counter`

## Requirements
- R1: After reset the count is 0, end_blk is 0, pulse is 0, the length register holds 16'hFFFF, the offset register holds 0, and the block is stopped.
- R2: While counting, each xfer_done strobe raises the count by one the next clock, wrapping from 16'hFFFF to 0 when no match occurs.
- R3: While stopped (after reset before any load, or after a finished block), xfer_done strobes leave count and end_blk unchanged.
- R4: With auto_rst low, a strobe that would make the count equal the length register sets the count to that length, sets end_blk and stops the block; end_blk stays 1 until the next load.
- R5: With auto_rst high, a strobe that would make the count equal the length register sets the count to 0, drives end_blk high for exactly one clock, and counting continues.
- R6: A length write is used by the comparison of every strobe in a later cycle, including strobes inside a block already running.
- R7: A load clears the count to 0 and end_blk to 0 on the next clock and starts counting; a strobe in the same cycle as a load is ignored.
- R8: pulse is high for one clock, in the clock where the count shows a new value reached by a strobe, when that value's low 8 bits equal the offset register and bus_req and bus_ack were both 1 with the strobe; otherwise it is 0.
- R9: During a long block, pulses repeat every 256 strobes, starting at the count equal to the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_done | input | 1 | One byte transfer or search has completed |
| bus_req | input | 1 | DMA is requesting the bus, active high |
| bus_ack | input | 1 | Bus has been granted to the DMA, active high |
| len_we | input | 1 | Write enable for the block length register |
| len_wdata | input | 16 | New block length |
| ofs_we | input | 1 | Write enable for the pulse offset register |
| ofs_wdata | input | 8 | New pulse offset |
| auto_rst | input | 1 | Restart at end of block instead of stopping |
| load | input | 1 | Clear the count and begin a block |
| count | output | 16 | Present byte count |
| end_blk | output | 1 | End of block: held when stopped, one clock on restart |
| pulse | output | 1 | Periodic pulse at offset-matching counts |

## Verification
The assertions rely on these conditions about the block's inputs:
- Every input is steady around the rising edge.
- A strobe and a register write in the same cycle are legal.
- A strobe in the same cycle as a load has no effect.

The bench drives every input just after the falling edge and holds it for a full clock. It applies loads together with strobes on purpose. Its pseudo-random phase mixes length rewrites, offset rewrites and auto-restart toggles with live strobes. Every cycle is compared against a behavioural model.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED_INIT = 2'd0,
        ST_COUNTING     = 2'd1,
        ST_BLOCK_DONE   = 2'd2
    } dbc_state_e;
endpackage

// File: rtl/dbc_regs.sv
module dbc_regs #(
    parameter int              CNT_W   = 16,
    parameter int              OFS_W   = 8,
    parameter logic [CNT_W-1:0] LEN_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_we,
    input  logic [CNT_W-1:0] len_wdata,
    input  logic             ofs_we,
    input  logic [OFS_W-1:0] ofs_wdata,
    output logic [CNT_W-1:0] len_q,
    output logic [OFS_W-1:0] ofs_q
);
    // length register: read live by the comparator every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_RST;
        end else if (len_we) begin
            len_q <= len_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (ofs_we) begin
            ofs_q <= ofs_wdata;
        end
    end
endmodule

// File: rtl/dbc_counter.sv
module dbc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             reload,
    input  logic [CNT_W-1:0] len_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] cnt_after,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_plus;

    always_comb begin
        cnt_plus  = count_q + ONE;
        hit       = (cnt_plus == len_q);
        // value the count moves to if the pending strobe is taken
        cnt_after = reload ? '0 : cnt_plus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr || reload) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= cnt_plus;
        end
    end
endmodule

// File: rtl/dbc_fsm.sv
module dbc_fsm
    import dbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       xfer_done,
    input  logic       auto_rst,
    input  logic       hit,
    output logic       clr,
    output logic       inc,
    output logic       reload,
    output logic       step,
    output logic       end_blk,
    output dbc_state_e state
);
    dbc_state_e state_nx;
    logic       restart_q;

    // decode of the strobe against the present state
    always_comb begin
        clr    = load;
        step   = (state == ST_COUNTING) && xfer_done && !load;
        reload = step && hit && auto_rst;
        inc    = step && !(hit && auto_rst);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED_INIT: begin
                if (load) state_nx = ST_COUNTING;
            end
            ST_COUNTING: begin
                if (load)                          state_nx = ST_COUNTING;
                else if (step && hit && !auto_rst) state_nx = ST_BLOCK_DONE;
            end
            ST_BLOCK_DONE: begin
                if (load) state_nx = ST_COUNTING;
            end
            default: state_nx = ST_STOPPED_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOPPED_INIT;
        end else begin
            state <= state_nx;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= reload;
        end
    end

    always_comb begin
        end_blk = (state == ST_BLOCK_DONE) || restart_q;
    end
endmodule

// File: rtl/dbc_pulse.sv
module dbc_pulse #(
    parameter int CNT_W = 16,
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_after,
    input  logic [OFS_W-1:0] ofs_q,
    input  logic             bus_req,
    input  logic             bus_ack,
    output logic             pulse
);
    logic bus_owned;
    logic low_match;

    always_comb begin
        bus_owned = bus_req && bus_ack;
        low_match = (cnt_after[OFS_W-1:0] == ofs_q);
    end

    // registered so the pulse lines up with the new count value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= step && low_match && bus_owned;
        end
    end
endmodule

// File: rtl/dma_blk_counter.sv
module dma_blk_counter
    import dbc_pkg::*;
#(
    parameter int              CNT_W   = 16,
    parameter int              OFS_W   = 8,
    parameter logic [CNT_W-1:0] LEN_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_done,
    input  logic             bus_req,
    input  logic             bus_ack,
    input  logic             len_we,
    input  logic [CNT_W-1:0] len_wdata,
    input  logic             ofs_we,
    input  logic [OFS_W-1:0] ofs_wdata,
    input  logic             auto_rst,
    input  logic             load,
    output logic [CNT_W-1:0] count,
    output logic             end_blk,
    output logic             pulse
);
    logic [CNT_W-1:0] len_q;
    logic [OFS_W-1:0] ofs_q;
    logic [CNT_W-1:0] cnt_after;
    logic             hit;
    logic             clr;
    logic             inc;
    logic             reload;
    logic             step;
    dbc_state_e       state;

    dbc_regs #(.CNT_W(CNT_W), .OFS_W(OFS_W), .LEN_RST(LEN_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_we    (len_we),
        .len_wdata (len_wdata),
        .ofs_we    (ofs_we),
        .ofs_wdata (ofs_wdata),
        .len_q     (len_q),
        .ofs_q     (ofs_q)
    );

    dbc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .inc       (inc),
        .reload    (reload),
        .len_q     (len_q),
        .count_q   (count),
        .cnt_after (cnt_after),
        .hit       (hit)
    );

    dbc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .xfer_done (xfer_done),
        .auto_rst  (auto_rst),
        .hit       (hit),
        .clr       (clr),
        .inc       (inc),
        .reload    (reload),
        .step      (step),
        .end_blk   (end_blk),
        .state     (state)
    );

    dbc_pulse #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_pls (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .cnt_after (cnt_after),
        .ofs_q     (ofs_q),
        .bus_req   (bus_req),
        .bus_ack   (bus_ack),
        .pulse     (pulse)
    );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker
    import dbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_done,
    input logic             bus_req,
    input logic             bus_ack,
    input logic             load,
    input logic [CNT_W-1:0] count,
    input logic             end_blk,
    input logic             pulse,
    input dbc_state_e       state
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R2
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNTING && xfer_done && !load) |=>
            ((count == $past(count) + ONE) || end_blk));

    // R3
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNTING && !load) |=> $stable(count));

    // R4
    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCK_DONE && !load) |=> end_blk);

    // R5
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (end_blk && state == ST_COUNTING) |-> (count == '0));

    // R7
    a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == '0 && !end_blk && state == ST_COUNTING));

    // R8
    a_r8_bus_owned: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(bus_req && bus_ack && xfer_done && !load));
endmodule

bind dma_blk_counter dbc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_done (xfer_done),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .load      (load),
    .count     (count),
    .end_blk   (end_blk),
    .pulse     (pulse),
    .state     (state)
);

// File: tb/sim_dma_blk_counter.sv
module sim_dma_blk_counter;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_done = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_ack = 1'b0;
    logic        len_we = 1'b0;
    logic [15:0] len_wdata = '0;
    logic        ofs_we = 1'b0;
    logic [7:0]  ofs_wdata = '0;
    logic        auto_rst = 1'b0;
    logic        load = 1'b0;
    logic [15:0] count;
    logic        end_blk;
    logic        pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference model state
    int m_cnt = 0;
    int m_st  = 0;   // 0 stopped-init, 1 counting, 2 block done
    int m_end = 0;
    int m_pls = 0;
    int m_len = 65535;
    int m_ofs = 0;
    int pulse_seen = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_blk_counter u0 (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .bus_req(bus_req),
        .bus_ack(bus_ack), .len_we(len_we), .len_wdata(len_wdata),
        .ofs_we(ofs_we), .ofs_wdata(ofs_wdata), .auto_rst(auto_rst),
        .load(load), .count(count), .end_blk(end_blk), .pulse(pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int nv;
        int restart;
        restart = 0;
        m_pls = 0;
        if (load) begin
            m_cnt = 0;
            m_st  = 1;
        end else if (m_st == 1 && xfer_done) begin
            nv = (m_cnt + 1) % 65536;
            if (nv == m_len) begin
                if (auto_rst) begin
                    nv = 0;
                    restart = 1;
                end else begin
                    m_st = 2;
                end
            end
            m_cnt = nv;
            m_pls = ((nv % 256) == m_ofs && bus_req && bus_ack) ? 1 : 0;
        end
        m_end = (m_st == 2 || restart == 1) ? 1 : 0;
        if (len_we) m_len = int'(len_wdata);
        if (ofs_we) m_ofs = int'(ofs_wdata);
    endtask

    task automatic compare();
        check(count == 16'(m_cnt), "R2 count", int'(count), m_cnt);
        check(end_blk == m_end[0], "R4/R5 end_blk", int'(end_blk), m_end);
        check(pulse == m_pls[0], "R8 pulse", int'(pulse), m_pls);
        if (pulse) pulse_seen++;
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        xfer_done = 1'b0; load = 1'b0; len_we = 1'b0; ofs_we = 1'b0;
    endtask

    task automatic set_len(input int v);
        len_we = 1'b1; len_wdata = 16'(v); tick();
    endtask

    task automatic set_ofs(input int v);
        ofs_we = 1'b1; ofs_wdata = 8'(v); tick();
    endtask

    task automatic do_load();
        load = 1'b1; tick();
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1'b1;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(count == 16'd0, "R1 count at reset", int'(count), 0);
        check(end_blk == 1'b0, "R1 end_blk at reset", int'(end_blk), 0);
        check(pulse == 1'b0, "R1 pulse at reset", int'(pulse), 0);
        rst_n = 1'b1;
        bus_req = 1'b1; bus_ack = 1'b1;

        // R3 strobes before any load
        strobes(4);
        check(count == 16'd0, "R3 ignored before load", int'(count), 0);

        // R4 stop at length without auto-restart, pulse at offset 3 (R8)
        set_len(5);
        set_ofs(3);
        do_load();
        strobes(5);
        check(count == 16'd5, "R4 count at end", int'(count), 5);
        check(end_blk == 1'b1, "R4 end_blk set", int'(end_blk), 1);
        strobes(3);
        check(count == 16'd5, "R3 ignored after end", int'(count), 5);
        check(end_blk == 1'b1, "R4 end_blk held", int'(end_blk), 1);

        // R7 load with simultaneous strobe
        load = 1'b1; xfer_done = 1'b1; tick();
        check(count == 16'd0 && end_blk == 1'b0, "R7 load wins", int'(count), 0);

        // R5 auto-restart
        auto_rst = 1'b1;
        set_len(4);
        pulse_seen = 0;
        strobes(12);
        check(count == 16'd0, "R5 count after three blocks", int'(count), 0);
        strobes(1);
        check(end_blk == 1'b0, "R5 end_blk one clock", int'(end_blk), 0);

        // R6 live length change inside a running block
        auto_rst = 1'b0;
        set_len(100);
        do_load();
        strobes(10);
        set_len(12);
        strobes(2);
        check(count == 16'd12 && end_blk == 1'b1, "R6 new length used", int'(count), 12);

        // R8 gating: bus not owned at the matching strobe
        set_len(50);
        set_ofs(2);
        do_load();
        strobes(1);
        bus_ack = 1'b0; xfer_done = 1'b1; tick();
        check(pulse == 1'b0, "R8 no pulse without bus_ack", int'(pulse), 0);
        bus_ack = 1'b1;
        tick();
        check(pulse == 1'b0, "R8 no retrigger on held count", int'(pulse), 0);

        // R9 periodic pulses every 256 strobes
        set_len(65535);
        set_ofs(16);
        do_load();
        pulse_seen = 0;
        strobes(600);
        check(pulse_seen == 3, "R9 pulse count over 600 strobes", pulse_seen, 3);

        // R2 wrap: shrink length below the count so the match comes after wrap
        set_len(10);
        strobes(65536 - 600 + 10);
        check(count == 16'd10 && end_blk == 1'b1, "R2 wrap then match", int'(count), 10);

        // mixed pseudo-random traffic against the model
        lfsr = 16'hACE1;
        do_load();
        for (int i = 0; i < 3000; i++) begin
            lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
            xfer_done = lfsr[0] | lfsr[1];
            bus_req   = lfsr[2] | lfsr[3];
            bus_ack   = lfsr[4] | lfsr[5];
            auto_rst  = lfsr[6];
            load      = (lfsr[11:7] == 5'd0);
            len_we    = (lfsr[14:12] == 3'd0);
            len_wdata = 16'(lfsr[10:7]);
            ofs_we    = (lfsr[15:13] == 3'd7);
            ofs_wdata = 8'(lfsr[4:1]);
            tick();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule